// File: doc/BRIEF.md
# Data-Cache Line Flush and Discard Engine

This block pairs a small direct-mapped data-cache tag store with a maintenance sequencer. The sequencer runs four cache-maintenance commands. Two of them write back dirty lines and then invalidate them. The other two invalidate without writing back, so any dirty contents are dropped. Each kind works either on the whole cache or on the single line that holds an address operand. Commands arrive as a 32-bit instruction word, together with the operand value, the current privilege level and a permission verdict (writable, cacheable) from an external protection unit.

A whole-cache command walks the sets from index 0 upward. A by-address command looks at one set and acts only when the stored tag matches. Each writeback goes out on a request/acknowledge port and must be acknowledged before that line is invalidated. Every accepted command ends with exactly one single-cycle pulse: completion, illegal instruction or store-access fault. A simple access port fills lines clean or dirty and reports hit and dirty status for any address, so the contents can be set up and inspected.

Top module: `dcache_maint_engine`

## Requirements
- R1: The instruction word is decoded with bits 19:15 masked out. A masked word of 0xFC000073 is a flush and 0xFC200073 is a discard. Bits 19:15 equal to zero select the whole-cache form and any other value selects the by-address form. Every other word raises the illegal-instruction pulse.
- R2: A command issued when cmd_priv is not 2'b11 (machine level) raises the illegal-instruction pulse one cycle after acceptance and leaves the cache unchanged.
- R3: A whole-cache flush writes back every valid dirty line in ascending set order, and afterwards every line is invalid.
- R4: A whole-cache discard invalidates every line and issues no writeback.
- R5: A by-address flush acts only on the set indexed by the address and only when the tag matches. A dirty match is written back and then invalidated, and a clean match is only invalidated. A miss and all other sets are left unchanged.
- R6: A by-address discard invalidates a matching line without any writeback.
- R7: A by-address command whose address is not writable raises the store-access-fault pulse one cycle after acceptance, issues no writeback and leaves the cache unchanged. Whole-cache commands ignore both permission inputs.
- R8: A by-address command on a writable but uncacheable address pulses done one cycle after acceptance and changes nothing.
- R9: wb_req stays high with a stable, line-aligned wb_addr until wb_ack is sampled high, and the line is invalidated only on that acknowledge.
- R10: A set that needs no writeback takes one cycle. A writeback adds one cycle plus the cycles spent waiting for the acknowledge. A whole-cache command responds SETS+1 cycles after acceptance when no writebacks are needed, and a by-address command responds 2 cycles after acceptance.
- R11: While busy is high, command and access inputs are ignored.
- R12: Each accepted command produces exactly one one-cycle pulse on done, illegal_insn or store_fault, and busy is low when that pulse is seen.
- R13: An idle access with acc_write=1 installs the line valid and dirty. With acc_write=0 it installs the line valid and clean, or keeps the dirty bit on a hit. probe_hit and probe_dirty report the line state for acc_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_insn | input | 32 | Instruction word |
| cmd_addr | input | ADDR_W | Address operand for the by-address forms |
| cmd_priv | input | 2 | Privilege level, 2'b11 = machine |
| perm_writable | input | 1 | Operand address is writable |
| perm_cacheable | input | 1 | Operand address is cacheable |
| busy | output | 1 | Engine is walking or writing back |
| done | output | 1 | Completion pulse |
| illegal_insn | output | 1 | Illegal-instruction pulse |
| store_fault | output | 1 | Store-access-fault pulse |
| acc_valid | input | 1 | Cache access strobe |
| acc_write | input | 1 | Access is a store (marks the line dirty) |
| acc_addr | input | ADDR_W | Access and probe address |
| probe_hit | output | 1 | Line for acc_addr is valid with a matching tag |
| probe_dirty | output | 1 | That line is dirty |
| wb_req | output | 1 | Writeback request |
| wb_addr | output | ADDR_W | Line-aligned writeback address |
| wb_ack | input | 1 | Writeback acknowledge |

## Verification
Whole-cache flushes run on a mix of dirty, clean and empty sets. A wrong walk order or a missed dirty line shows up as a writeback address that differs from the one the reference queue expects. By-address commands are tried on a dirty hit, a tag miss in an occupied set, an unwritable address and an uncacheable address, which separates the line-selection logic from the permission handling. Discards of dirty lines show that invalidation happens without a writeback. A non-machine command and a cache store are injected in the middle of a walk to show that both are refused while busy.

// File: rtl/dcm_pkg.sv
// Shared encodings for the data-cache maintenance engine.
package dcm_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_WB} eng_state_t;
    localparam logic [31:0] FLUSH_WORD   = 32'hFC000073;
    localparam logic [31:0] DISCARD_WORD = 32'hFC200073;
    localparam logic [31:0] RS1_FIELD    = 32'h000F8000;
    localparam logic [1:0]  PRIV_MACHINE = 2'b11;
endpackage

// File: rtl/dcm_decode.sv
// Classifies an instruction word as one of the maintenance commands.
// Assumes the word is stable while cmd_valid is high; purely combinational.
module dcm_decode
    import dcm_pkg::*;
(
    input  logic [31:0] insn,
    output logic        known_op,
    output logic        discard_op,
    output logic        whole_cache
);
    logic [31:0] masked;

    // Strip the register field and compare against the two base words.
    always_comb begin
        masked      = insn & ~RS1_FIELD;
        known_op    = (masked == FLUSH_WORD) || (masked == DISCARD_WORD);
        discard_op  = (masked == DISCARD_WORD);
        whole_cache = ((insn & RS1_FIELD) == 32'h0);
    end
endmodule

// File: rtl/dcm_tag_store.sv
// Tag, valid and dirty state of a direct-mapped cache with one line per set.
// Assumes the access port and the invalidate port are never active together.
module dcm_tag_store #(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 5,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              probe_hit,
    output logic              probe_dirty,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [ADDR_W-OFFS_W-IDX_W-1:0] rd_tag,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_idx
);
    localparam int SETS  = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - OFFS_W - IDX_W;

    logic [SETS-1:0]  valid_r;
    logic [SETS-1:0]  dirty_r;
    logic [TAG_W-1:0] tag_r [SETS];
    logic [IDX_W-1:0] acc_idx;
    logic [TAG_W-1:0] acc_tag;
    logic             acc_hit;

    // Split the access address and look it up.
    always_comb begin
        acc_idx     = acc_addr[OFFS_W +: IDX_W];
        acc_tag     = acc_addr[ADDR_W-1 -: TAG_W];
        acc_hit     = valid_r[acc_idx] && (tag_r[acc_idx] == acc_tag);
        probe_hit   = acc_hit;
        probe_dirty = acc_hit && dirty_r[acc_idx];
        rd_valid    = valid_r[rd_idx];
        rd_dirty    = dirty_r[rd_idx];
        rd_tag      = tag_r[rd_idx];
    end

    // Update line state from accesses and maintenance invalidates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_r <= '0;
            dirty_r <= '0;
        end else if (acc_en) begin
            valid_r[acc_idx] <= 1'b1;
            tag_r[acc_idx]   <= acc_tag;
            dirty_r[acc_idx] <= acc_write || (acc_hit && dirty_r[acc_idx]);
        end else if (inv_en) begin
            valid_r[inv_idx] <= 1'b0;
            dirty_r[inv_idx] <= 1'b0;
        end
    end
endmodule

// File: rtl/dcm_walker.sv
// Maintenance sequencer: accepts a decoded command, checks privilege and
// permission before touching the cache, then visits sets in ascending order
// and writes back dirty lines for flushes. Assumes wb_ack only while wb_req.
module dcm_walker
    import dcm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 5,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [1:0]        cmd_priv,
    input  logic              perm_writable,
    input  logic              perm_cacheable,
    input  logic              known_op,
    input  logic              discard_op,
    input  logic              whole_cache,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_valid,
    input  logic              rd_dirty,
    input  logic [ADDR_W-OFFS_W-IDX_W-1:0] rd_tag,
    output logic              inv_en,
    output logic [IDX_W-1:0]  inv_idx,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    input  logic              wb_ack,
    output logic              busy,
    output logic              done,
    output logic              illegal_insn,
    output logic              store_fault
);
    localparam int TAG_W = ADDR_W - OFFS_W - IDX_W;

    eng_state_t       state;
    logic [IDX_W-1:0] cur_idx, last_idx;
    logic [TAG_W-1:0] tgt_tag;
    logic             whole_q, discard_q;
    logic             done_q, ill_q, flt_q;
    logic             line_match, need_wb, advance;

    // Decide what the current set needs and whether the walk moves on.
    always_comb begin
        line_match = rd_valid && (whole_q || rd_tag == tgt_tag);
        need_wb    = line_match && !discard_q && rd_dirty;
        inv_en     = 1'b0;
        advance    = 1'b0;
        case (state)
            ST_WALK: if (!need_wb) begin
                inv_en  = line_match;
                advance = 1'b1;
            end
            ST_WB: if (wb_ack) begin
                inv_en  = 1'b1;
                advance = 1'b1;
            end
            default: ;
        endcase
    end

    assign rd_idx       = cur_idx;
    assign inv_idx      = cur_idx;
    assign wb_req       = (state == ST_WB);
    assign wb_addr      = {rd_tag, cur_idx, {OFFS_W{1'b0}}};
    assign busy         = (state != ST_IDLE);
    assign done         = done_q;
    assign illegal_insn = ill_q;
    assign store_fault  = flt_q;

    // Command acceptance, walk sequencing and response pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_idx   <= '0;
            last_idx  <= '0;
            tgt_tag   <= '0;
            whole_q   <= 1'b0;
            discard_q <= 1'b0;
            done_q    <= 1'b0;
            ill_q     <= 1'b0;
            flt_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            ill_q  <= 1'b0;
            flt_q  <= 1'b0;
            if (state == ST_IDLE) begin
                if (cmd_valid) begin
                    if (!known_op || cmd_priv != PRIV_MACHINE) begin
                        ill_q <= 1'b1;
                    end else if (!whole_cache && !perm_writable) begin
                        flt_q <= 1'b1;
                    end else if (!whole_cache && !perm_cacheable) begin
                        done_q <= 1'b1;
                    end else begin
                        state     <= ST_WALK;
                        whole_q   <= whole_cache;
                        discard_q <= discard_op;
                        tgt_tag   <= cmd_addr[ADDR_W-1 -: TAG_W];
                        cur_idx   <= whole_cache ? '0 : cmd_addr[OFFS_W +: IDX_W];
                        last_idx  <= whole_cache ? '1 : cmd_addr[OFFS_W +: IDX_W];
                    end
                end
            end else if (advance) begin
                if (cur_idx == last_idx) begin
                    state  <= ST_IDLE;
                    done_q <= 1'b1;
                end else begin
                    cur_idx <= cur_idx + 1'b1;
                    state   <= ST_WALK;
                end
            end else if (state == ST_WALK && need_wb) begin
                state <= ST_WB;
            end
        end
    end
endmodule

// File: rtl/dcache_maint_engine.sv
// Top level: decoder, sequencer and tag store of the data-cache maintenance
// engine. Accesses are taken only while the sequencer is idle.
module dcache_maint_engine #(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 5,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [31:0]       cmd_insn,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [1:0]        cmd_priv,
    input  logic              perm_writable,
    input  logic              perm_cacheable,
    output logic              busy,
    output logic              done,
    output logic              illegal_insn,
    output logic              store_fault,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              probe_hit,
    output logic              probe_dirty,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    input  logic              wb_ack
);
    localparam int TAG_W = ADDR_W - OFFS_W - IDX_W;

    logic             known_op, discard_op, whole_cache;
    logic [IDX_W-1:0] rd_idx, inv_idx;
    logic             rd_valid, rd_dirty, inv_en;
    logic [TAG_W-1:0] rd_tag;

    dcm_decode u_dec (
        .insn        (cmd_insn),
        .known_op    (known_op),
        .discard_op  (discard_op),
        .whole_cache (whole_cache)
    );

    dcm_walker #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .IDX_W(IDX_W)) u_walk (
        .clk, .rst_n, .cmd_valid, .cmd_addr, .cmd_priv,
        .perm_writable, .perm_cacheable,
        .known_op, .discard_op, .whole_cache,
        .rd_idx, .rd_valid, .rd_dirty, .rd_tag,
        .inv_en, .inv_idx,
        .wb_req, .wb_addr, .wb_ack,
        .busy, .done, .illegal_insn, .store_fault
    );

    dcm_tag_store #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .IDX_W(IDX_W)) u_tags (
        .clk, .rst_n,
        .acc_en    (acc_valid && !busy),
        .acc_write, .acc_addr, .probe_hit, .probe_dirty,
        .rd_idx, .rd_valid, .rd_dirty, .rd_tag,
        .inv_en, .inv_idx
    );
endmodule

// File: rtl/dcm_checker.sv
// Protocol and outcome properties of the maintenance engine, bound to the top.
module dcm_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [31:0]       cmd_insn,
    input logic [1:0]        cmd_priv,
    input logic              busy,
    input logic              done,
    input logic              illegal_insn,
    input logic              store_fault,
    input logic              wb_req,
    input logic [ADDR_W-1:0] wb_addr,
    input logic              wb_ack
);
    logic disc_active;

    // Remember whether the command being walked is a discard (word bit 21).
    always_ff @(posedge clk) begin
        if (!rst_n) disc_active <= 1'b0;
        else if (cmd_valid && !busy) disc_active <= cmd_insn[21];
    end

    p_illegal_non_m_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_priv != 2'b11) |=> illegal_insn);

    p_discard_no_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && disc_active) |-> !wb_req);

    p_wb_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr)));

    p_wb_in_walk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> busy);

    p_refuse_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !(illegal_insn || store_fault));

    p_single_resp_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({done, illegal_insn, store_fault}) <= 1);

    p_resp_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done || illegal_insn || store_fault) |-> !busy);
endmodule

bind dcache_maint_engine dcm_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_insn     (cmd_insn),
    .cmd_priv     (cmd_priv),
    .busy         (busy),
    .done         (done),
    .illegal_insn (illegal_insn),
    .store_fault  (store_fault),
    .wb_req       (wb_req),
    .wb_addr      (wb_addr),
    .wb_ack       (wb_ack)
);

// File: tb/dcache_maint_engine_tb.sv
module dcache_maint_engine_tb;
    localparam int SETS = 8;
    localparam int ACK_DLY = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_insn = '0;
    logic [31:0] cmd_addr = '0;
    logic [1:0]  cmd_priv = 2'b11;
    logic        perm_writable = 1'b1, perm_cacheable = 1'b1;
    logic        busy, done, illegal_insn, store_fault;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        probe_hit, probe_dirty;
    logic        wb_req;
    logic [31:0] wb_addr;
    logic        wb_ack = 1'b0;

    int vectors = 0;
    int fails = 0;
    int m_v [SETS];
    int m_d [SETS];
    int m_t [SETS];
    int wbq [$];

    always #10 clk = ~clk;

    dcache_maint_engine u_dut (
        .clk, .rst_n, .cmd_valid, .cmd_insn, .cmd_addr, .cmd_priv,
        .perm_writable, .perm_cacheable, .busy, .done, .illegal_insn,
        .store_fault, .acc_valid, .acc_write, .acc_addr, .probe_hit,
        .probe_dirty, .wb_req, .wb_addr, .wb_ack
    );

    function automatic logic [31:0] line_addr(int tag, int set);
        return (32'(tag) << 8) | (32'(set) << 5);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R13: access from idle; model mirrors the fill rule.
    task automatic access(input int tag, input int set, input bit wr);
        @(negedge clk);
        acc_addr = line_addr(tag, set); acc_write = wr; acc_valid = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
        m_d[set] = (wr || (m_v[set] != 0 && m_t[set] == tag && m_d[set] != 0)) ? 1 : 0;
        m_v[set] = 1; m_t[set] = tag;
    endtask

    // R13: probe every set at the last tag the model holds there.
    task automatic probe_all(input string req);
        for (int s = 0; s < SETS; s++) begin
            acc_addr = line_addr(m_t[s], s);
            #1;
            chk(probe_hit == (m_v[s] != 0), req, probe_hit, m_v[s]);
            chk(probe_dirty == (m_v[s] != 0 && m_d[s] != 0), req, probe_dirty, m_d[s]);
        end
    endtask

    // Issue one command and compare its outcome cycle by cycle with the model.
    task automatic run_cmd(input string req, input logic [31:0] insn, input logic [31:0] addr,
                           input logic [1:0] priv, input bit wr, input bit cach, input bit inject);
        bit legal, disc, whole, walking;
        int kind, nwb, lat, n, cnt, got;
        int s, tg;
        legal = (((insn & 32'hFFF07FFF) == 32'hFC000073) ||
                 ((insn & 32'hFFF07FFF) == 32'hFC200073)) && priv == 2'b11;
        disc  = insn[21];
        whole = (insn[19:15] == 5'd0);
        walking = legal && (whole || (wr && cach));
        wbq.delete();
        kind = 0;
        if (!legal) kind = 1;
        else if (!whole && !wr) kind = 2;
        else if (walking) begin
            for (int i = 0; i < SETS; i++) begin
                s = whole ? i : int'(addr[7:5]);
                tg = int'(addr >> 8);
                if (m_v[s] != 0 && (whole || m_t[s] == tg)) begin
                    if (!disc && m_d[s] != 0) wbq.push_back(int'(line_addr(m_t[s], s)));
                    m_v[s] = 0; m_d[s] = 0;
                end
                if (!whole) break;
            end
        end
        nwb = wbq.size();
        lat = !walking ? 1 : (whole ? SETS + 1 : 2) + nwb * ACK_DLY;

        @(negedge clk);
        cmd_insn = insn; cmd_addr = addr; cmd_priv = priv;
        perm_writable = wr; perm_cacheable = cach; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 1; cnt = 0; got = -1;
        while (n < 300) begin
            if (n == 1) chk(busy == walking, {req, " busy"}, busy, walking);
            if (inject && n == 2) begin
                cmd_insn = 32'hFC000073; cmd_priv = 2'b00; cmd_valid = 1'b1;
                acc_addr = line_addr(99, 7); acc_write = 1'b1; acc_valid = 1'b1;
            end
            if (inject && n == 3) begin
                cmd_valid = 1'b0; acc_valid = 1'b0;
            end
            if (wb_ack) begin
                wb_ack = 1'b0; cnt = 0;
            end else if (wb_req) begin
                if (wbq.size() == 0) chk(1'b0, {req, " R9 unexpected wb"}, wb_addr, 0);
                else chk(wb_addr == wbq[0], {req, " R9 wb addr"}, wb_addr, wbq[0]);
                cnt++;
                if (cnt == ACK_DLY) begin
                    wb_ack = 1'b1;
                    if (wbq.size() != 0) void'(wbq.pop_front());
                end
            end
            if (done || illegal_insn || store_fault) begin
                got = done ? 0 : (illegal_insn ? 1 : 2);
                break;
            end
            @(negedge clk);
            n++;
        end
        chk(got == kind, {req, " R12 outcome"}, got, kind);
        chk(n == lat, {req, " R10 latency"}, n, lat);
        chk(wbq.size() == 0, {req, " R9 missing wb"}, wbq.size(), 0);
        @(negedge clk);
        chk(!(done || illegal_insn || store_fault), {req, " R12 pulse width"}, done, 0);
        probe_all({req, " state"});
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int s = 0; s < SETS; s++) begin m_v[s] = 0; m_d[s] = 0; m_t[s] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !illegal_insn && !store_fault && !wb_req, "R12 reset idle", busy, 0);
        probe_all("R13 reset empty");

        access(1, 0, 1); access(2, 1, 0); access(3, 2, 1);
        access(4, 3, 0); access(5, 5, 1); access(5, 5, 0);
        probe_all("R13 fill");

        run_cmd("R2 user-level flush", 32'hFC000073, 0, 2'b01, 1, 1, 0);
        run_cmd("R1 unknown word", 32'h00000013, 0, 2'b11, 1, 1, 0);
        run_cmd("R1 near-miss word", 32'hFC100073, 0, 2'b11, 1, 1, 0);
        run_cmd("R8 uncacheable", 32'hFC000073 | (5'd10 << 15), line_addr(3, 2), 2'b11, 1, 0, 0);
        run_cmd("R7 unwritable", 32'hFC000073 | (5'd10 << 15), line_addr(3, 2), 2'b11, 0, 1, 0);
        run_cmd("R5 addr flush dirty hit", 32'hFC000073 | (5'd10 << 15), line_addr(3, 2) + 32'h14, 2'b11, 1, 1, 0);
        run_cmd("R5 addr flush tag miss", 32'hFC000073 | (5'd11 << 15), line_addr(7, 0), 2'b11, 1, 1, 0);
        run_cmd("R5 addr flush clean hit", 32'hFC000073 | (5'd11 << 15), line_addr(2, 1), 2'b11, 1, 1, 0);
        run_cmd("R6 addr discard dirty", 32'hFC200073 | (5'd9 << 15), line_addr(5, 5), 2'b11, 1, 1, 0);
        run_cmd("R3 R11 R7 whole flush", 32'hFC000073, 0, 2'b11, 0, 0, 1);

        access(8, 0, 1); access(9, 4, 1); access(10, 7, 1); access(11, 6, 0);
        run_cmd("R4 whole discard", 32'hFC200073, 0, 2'b11, 1, 1, 0);

        access(12, 1, 1); access(13, 3, 1); access(14, 6, 1); access(15, 2, 0);
        run_cmd("R3 whole flush order", 32'hFC000073, 0, 2'b11, 1, 1, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule